// File: doc/BRIEF.md
# Writable Opcode Dispatch Map

This block turns machine-level opcode bytes into microprogram entry addresses for a microcoded processor. It keeps four banks of loadable dispatch tables. Each bank holds a primary table indexed by the opcode byte and an extended table for the second byte of escaped opcodes. A table word is a 12-bit microaddress, an escape flag and an even-parity bit. The parity bit is generated when the word is written and is checked each time the word is read for a dispatch.

The microsequencer presents one opcode per cycle on the lookup port. The matching microaddress appears on the next cycle, so decoding the next instruction overlaps executing the current one. A held bank-select register picks the active instruction set. Software reloads it on a context switch, for example to move between a kernel bank and a user bank whose privileged opcodes point at a trap routine.

A primary word with its escape flag set holds the block busy for one extra cycle. During that cycle the next opcode byte indexes the extended table of the same bank. A parity mismatch substitutes a fixed fault microaddress and sets a sticky error flag.

Top module: `dmap_dispatch`

## Requirements
- R1: A cycle with `disp_valid_i` high, and `busy_o` low, starts a lookup of `disp_opc_i` in the primary table of the active bank. On the next cycle `uaddr_valid_o` is high and `uaddr_o` carries that entry's microaddress.
- R2: Lookups may be issued on consecutive cycles, and each gives its result one cycle later with no gap.
- R3: A cycle with `wr_en_i` high stores `wr_uaddr_i` and `wr_esc_i` at opcode `wr_opc_i` of bank `wr_bank_i`. `wr_ext_i` = 0 selects the primary table and 1 selects the extended table. A later lookup returns the stored value. A lookup of the same entry in the same cycle as the write returns the old contents.
- R4: A cycle with `bank_we_i` high loads `bank_sel_i` into the bank select. The new bank applies to lookups started on later cycles. A lookup started in the same cycle still uses the previous bank. Reset selects bank 0.
- R5: If the primary word read has its escape flag set and good parity, `busy_o` is high and `uaddr_valid_o` is low for exactly one cycle. In that cycle `disp_opc_i` indexes the extended table, and the result appears on the following cycle. `disp_valid_i` is ignored while `busy_o` is high, so no second result follows.
- R6: A bank-select write made during the busy cycle does not change the bank used for the extended lookup.
- R7: The escape flag of an extended-table word is ignored. The word is output directly and `busy_o` stays low.
- R8: A word read with bad parity gives `uaddr_valid_o` high with `uaddr_o` = the fault address (default 0xFF0). The word never starts an escape, even if its escape flag is set.
- R9: `par_err_o` goes high in the same cycle as the first faulty result and stays high until reset.
- R10: While reset is asserted and just after it is released, `uaddr_valid_o`, `busy_o` and `par_err_o` are low.
- R11: A write with `wr_par_inv_i` high stores the inverted parity bit. Parity is even over the stored {parity, escape, microaddress}, so that word fails its check on every read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_bank_i | input | 2 | Bank to write |
| wr_ext_i | input | 1 | 0 primary table, 1 extended table |
| wr_opc_i | input | 8 | Entry index to write |
| wr_uaddr_i | input | 12 | Microaddress to store |
| wr_esc_i | input | 1 | Escape flag to store |
| wr_par_inv_i | input | 1 | Store inverted parity (diagnostic) |
| bank_we_i | input | 1 | Load bank select |
| bank_sel_i | input | 2 | New active bank |
| disp_valid_i | input | 1 | Lookup request |
| disp_opc_i | input | 8 | Opcode byte, or second byte while busy |
| uaddr_valid_o | output | 1 | Result valid |
| uaddr_o | output | 12 | Next microaddress |
| busy_o | output | 1 | Escape continuation cycle |
| par_err_o | output | 1 | Sticky parity error |

## Verification
Two pairs of functions can fall in the same cycle: a table write and a lookup of that same entry, and a bank-select write and the extended lookup of an escape. The bench drives each pair in one cycle on purpose. It then checks that the lookup returns the pre-write word and that the extended lookup uses the bank latched at the escape. It also checks that the bank change applies only to the following lookup. Random lookups with random bank switches and table rewrites are compared against a bench-side table model.

// File: rtl/dmap_pkg.sv
package dmap_pkg;
  localparam int unsigned NUM_BANKS = 4;
  localparam int unsigned OPC_W     = 8;
  localparam int unsigned UADDR_W   = 12;
  localparam int unsigned BANK_W    = $clog2(NUM_BANKS);
  localparam int unsigned TBL_AW    = OPC_W + 1;  // {ext, opcode}
  localparam int unsigned TBL_DEPTH = 2 ** TBL_AW;

  typedef logic [BANK_W-1:0]  bank_t;
  typedef logic [OPC_W-1:0]   opc_t;
  typedef logic [UADDR_W-1:0] uaddr_t;

  typedef struct packed {
    logic   par;
    logic   esc;
    uaddr_t uaddr;
  } dmap_word_t;

  // even parity bit over payload
  function automatic logic calc_par(input logic esc, input uaddr_t ua);
    return ^{esc, ua};
  endfunction
endpackage

// File: rtl/dmap_bank_reg.sv
module dmap_bank_reg
  import dmap_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sel_we_i,
  input  bank_t sel_i,
  output bank_t bank_o
);
  bank_t bank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       bank_q <= '0;
    else if (sel_we_i) bank_q <= sel_i;
  end

  assign bank_o = bank_q;
endmodule

// File: rtl/dmap_table_ram.sv
module dmap_table_ram
  import dmap_pkg::*;
(
  input  logic       clk_i,
  input  logic       we_i,
  input  bank_t      wbank_i,
  input  logic       wext_i,
  input  opc_t       wopc_i,
  input  dmap_word_t wword_i,
  input  logic       re_i,
  input  bank_t      rbank_i,
  input  logic       rext_i,
  input  opc_t       ropc_i,
  output dmap_word_t rword_o
);
  dmap_word_t bank_rd [NUM_BANKS];
  bank_t      rbank_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dmap_word_t mem [TBL_DEPTH];
    dmap_word_t rd_q;
    logic       we_b, re_b;

    assign we_b = we_i && (wbank_i == bank_t'(b));
    assign re_b = re_i && (rbank_i == bank_t'(b));

    // read-before-write on a same-cycle collision
    always_ff @(posedge clk_i) begin
      if (we_b) mem[{wext_i, wopc_i}] <= wword_i;
      if (re_b) rd_q <= mem[{rext_i, ropc_i}];
    end

    assign bank_rd[b] = rd_q;
  end

  always_ff @(posedge clk_i) begin
    if (re_i) rbank_q <= rbank_i;
  end

  assign rword_o = bank_rd[rbank_q];
endmodule

// File: rtl/dmap_par_chk.sv
module dmap_par_chk
  import dmap_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       chk_i,
  input  dmap_word_t word_i,
  output logic       bad_o,
  output logic       err_o
);
  logic err_q;

  assign bad_o = chk_i && (^word_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    err_q <= 1'b0;
    else if (bad_o) err_q <= 1'b1;
  end

  assign err_o = err_q | bad_o;
endmodule

// File: rtl/dmap_dispatch.sv
module dmap_dispatch
  import dmap_pkg::*;
#(
  parameter logic [UADDR_W-1:0] FAULT_UADDR = 12'hFF0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [BANK_W-1:0]  wr_bank_i,
  input  logic               wr_ext_i,
  input  logic [OPC_W-1:0]   wr_opc_i,
  input  logic [UADDR_W-1:0] wr_uaddr_i,
  input  logic               wr_esc_i,
  input  logic               wr_par_inv_i,
  input  logic               bank_we_i,
  input  logic [BANK_W-1:0]  bank_sel_i,
  input  logic               disp_valid_i,
  input  logic [OPC_W-1:0]   disp_opc_i,
  output logic               uaddr_valid_o,
  output logic [UADDR_W-1:0] uaddr_o,
  output logic               busy_o,
  output logic               par_err_o
);
  bank_t      cur_bank, rd_bank, esc_bank_q;
  logic       prim_req, rd_en;
  logic       rd_valid_q, rd_ext_q;
  logic       rd_bad;
  dmap_word_t wr_word, rd_word;

  dmap_bank_reg i_bank_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_we_i (bank_we_i),
    .sel_i    (bank_sel_i),
    .bank_o   (cur_bank)
  );

  assign wr_word.par   = calc_par(wr_esc_i, wr_uaddr_i) ^ wr_par_inv_i;
  assign wr_word.esc   = wr_esc_i;
  assign wr_word.uaddr = wr_uaddr_i;

  // busy cycle consumes disp_opc_i as second byte
  assign prim_req = disp_valid_i && !busy_o;
  assign rd_en    = prim_req || busy_o;
  assign rd_bank  = busy_o ? esc_bank_q : cur_bank;

  dmap_table_ram i_table_ram (
    .clk_i   (clk_i),
    .we_i    (wr_en_i),
    .wbank_i (wr_bank_i),
    .wext_i  (wr_ext_i),
    .wopc_i  (wr_opc_i),
    .wword_i (wr_word),
    .re_i    (rd_en),
    .rbank_i (rd_bank),
    .rext_i  (busy_o),
    .ropc_i  (disp_opc_i),
    .rword_o (rd_word)
  );

  dmap_par_chk i_par_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chk_i  (rd_valid_q),
    .word_i (rd_word),
    .bad_o  (rd_bad),
    .err_o  (par_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_ext_q   <= 1'b0;
      esc_bank_q <= '0;
    end else begin
      rd_valid_q <= rd_en;
      rd_ext_q   <= busy_o;
      if (prim_req) esc_bank_q <= cur_bank;
    end
  end

  assign busy_o        = rd_valid_q && !rd_ext_q && rd_word.esc && !rd_bad;
  assign uaddr_valid_o = rd_valid_q && !busy_o;

  always_comb begin
    if (!uaddr_valid_o) uaddr_o = '0;
    else if (rd_bad)    uaddr_o = FAULT_UADDR;
    else                uaddr_o = rd_word.uaddr;
  end
endmodule

// File: rtl/dmap_dispatch_chk.sv
module dmap_dispatch_chk
  import dmap_pkg::*;
#(
  parameter logic [UADDR_W-1:0] FAULT_UADDR = 12'hFF0
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               disp_valid_i,
  input logic               uaddr_valid_o,
  input logic [UADDR_W-1:0] uaddr_o,
  input logic               busy_o,
  input logic               par_err_o
);
  a_r5_busy_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  a_r5_busy_no_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !uaddr_valid_o);

  a_r5_busy_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> $past(disp_valid_i));

  a_r1_result_has_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uaddr_valid_o |-> ($past(disp_valid_i) || $past(busy_o)));

  a_r9_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    par_err_o |=> par_err_o);

  a_r8_first_fault_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uaddr_valid_o && $rose(par_err_o)) |-> (uaddr_o == FAULT_UADDR));

  a_r9_err_with_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(par_err_o) |-> uaddr_valid_o);
endmodule

bind dmap_dispatch dmap_dispatch_chk #(.FAULT_UADDR(FAULT_UADDR)) i_dmap_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .disp_valid_i  (disp_valid_i),
  .uaddr_valid_o (uaddr_valid_o),
  .uaddr_o       (uaddr_o),
  .busy_o        (busy_o),
  .par_err_o     (par_err_o)
);

// File: tb/test_dmap_dispatch.sv
module test_dmap_dispatch;
  import dmap_pkg::*;

  localparam logic [11:0] FAULT = 12'hFF0;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_ext_i = 1'b0, wr_esc_i = 1'b0, wr_par_inv_i = 1'b0;
  logic [1:0]  wr_bank_i = '0, bank_sel_i = '0;
  logic [7:0]  wr_opc_i = '0, disp_opc_i = '0;
  logic [11:0] wr_uaddr_i = '0;
  logic        bank_we_i = 1'b0, disp_valid_i = 1'b0;
  logic        uaddr_valid_o, busy_o, par_err_o;
  logic [11:0] uaddr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [11:0] m_ua  [NUM_BANKS][2][256];
  bit          m_esc [NUM_BANKS][2][256];
  bit          m_bad [NUM_BANKS][2][256];
  int          mbank = 0;
  bit          err_exp = 0;

  always #10 clk_i = ~clk_i;

  dmap_dispatch i_dmap_dispatch (
    .clk_i, .rst_ni, .wr_en_i, .wr_bank_i, .wr_ext_i, .wr_opc_i, .wr_uaddr_i,
    .wr_esc_i, .wr_par_inv_i, .bank_we_i, .bank_sel_i, .disp_valid_i,
    .disp_opc_i, .uaddr_valid_o, .uaddr_o, .busy_o, .par_err_o
  );

  function automatic logic [11:0] gen_ua(input int b, input int e, input int o);
    logic [31:0] v;
    v = (b * 32'h3a5) ^ (e * 32'h6c3) ^ (o * 32'd37) ^ 32'h011;
    return v[11:0];
  endfunction

  function automatic bit gen_esc(input int b, input int e, input int o);
    return (e == 0 && o == 8'hF0 + b) || (e == 1 && o == 8'h33);
  endfunction

  function automatic logic [31:0] exp_ua(input int b, input int e, input int o);
    return m_bad[b][e][o] ? {20'd0, FAULT} : {20'd0, m_ua[b][e][o]};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr_one(input int b, input int e, input int o,
                        input logic [11:0] ua, input bit esc, input bit inv);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_bank_i = b[1:0]; wr_ext_i = e[0]; wr_opc_i = o[7:0];
    wr_uaddr_i = ua; wr_esc_i = esc; wr_par_inv_i = inv;
    m_ua[b][e][o] = ua; m_esc[b][e][o] = esc; m_bad[b][e][o] = inv;
    @(negedge clk_i);
    wr_en_i = 1'b0; wr_par_inv_i = 1'b0;
  endtask

  task automatic set_bank(input int b);
    @(negedge clk_i);
    bank_we_i = 1'b1; bank_sel_i = b[1:0];
    @(negedge clk_i);
    bank_we_i = 1'b0;
    mbank = b;
  endtask

  task automatic dispatch(input int o, input int o2, input string req);
    int b;
    b = mbank;
    @(negedge clk_i);
    disp_valid_i = 1'b1; disp_opc_i = o[7:0];
    @(negedge clk_i);
    disp_valid_i = 1'b0;
    if (m_esc[b][0][o] && !m_bad[b][0][o]) begin
      check(req, "escape busy", busy_o, 1);
      check(req, "escape holds result", uaddr_valid_o, 0);
      disp_opc_i = o2[7:0];
      @(negedge clk_i);
      check(req, "ext valid", uaddr_valid_o, 1);
      check(req, "ext uaddr", uaddr_o, exp_ua(b, 1, o2));
      check(req, "ext no second busy", busy_o, 0);
      if (m_bad[b][1][o2]) err_exp = 1;
    end else begin
      check(req, "valid", uaddr_valid_o, 1);
      check(req, "uaddr", uaddr_o, exp_ua(b, 0, o));
      check(req, "no busy", busy_o, 0);
      if (m_bad[b][0][o]) err_exp = 1;
    end
    check(req, "par_err", par_err_o, err_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int prev_o;
    int b0;
    void'($urandom(32'h5eed));

    // R10 reset state
    repeat (3) @(negedge clk_i);
    check("R10", "valid in reset", uaddr_valid_o, 0);
    check("R10", "busy in reset", busy_o, 0);
    check("R10", "par_err in reset", par_err_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R10", "valid after reset", uaddr_valid_o, 0);
    check("R10", "par_err after reset", par_err_o, 0);

    // R3 load all tables
    for (int b = 0; b < NUM_BANKS; b++)
      for (int e = 0; e < 2; e++)
        for (int o = 0; o < 256; o++)
          wr_one(b, e, o, gen_ua(b, e, o), gen_esc(b, e, o), 1'b0);

    // R1 directed, bank 0 after reset (R4)
    dispatch(0, 0, "R1");
    dispatch(255, 0, "R1");
    dispatch(8'h7F, 0, "R4");

    // R2 back-to-back burst
    prev_o = 0;
    for (int i = 0; i <= 16; i++) begin
      @(negedge clk_i);
      if (i > 0) begin
        check("R2", "burst valid", uaddr_valid_o, 1);
        check("R2", "burst uaddr", uaddr_o, exp_ua(mbank, 0, prev_o));
      end
      if (i < 16) begin
        prev_o = $urandom_range(0, 127);
        disp_valid_i = 1'b1; disp_opc_i = prev_o[7:0];
      end else disp_valid_i = 1'b0;
    end
    @(negedge clk_i);
    check("R2", "burst idle", uaddr_valid_o, 0);

    // R4 bank switch, and same-cycle switch with lookup
    set_bank(2);
    dispatch(10, 0, "R4");
    @(negedge clk_i);
    bank_we_i = 1'b1; bank_sel_i = 2'd3; disp_valid_i = 1'b1; disp_opc_i = 8'd10;
    @(negedge clk_i);
    bank_we_i = 1'b0; disp_valid_i = 1'b0;
    check("R4", "same-cycle switch uses old bank", uaddr_o, exp_ua(2, 0, 10));
    mbank = 3;
    dispatch(10, 0, "R4");

    // R5 escape in bank 3
    dispatch(8'hF3, 8'h21, "R5");

    // R5/R6 valid ignored while busy, bank switch during busy
    @(negedge clk_i);
    disp_valid_i = 1'b1; disp_opc_i = 8'hF3;
    @(negedge clk_i);
    check("R5", "busy", busy_o, 1);
    disp_opc_i = 8'h44; bank_we_i = 1'b1; bank_sel_i = 2'd1;
    @(negedge clk_i);
    disp_valid_i = 1'b0; bank_we_i = 1'b0;
    check("R6", "ext lookup keeps bank", uaddr_o, exp_ua(3, 1, 8'h44));
    @(negedge clk_i);
    check("R5", "valid during busy ignored", uaddr_valid_o, 0);
    mbank = 1;
    dispatch(5, 0, "R6");

    // R7 escape flag in extended word ignored
    dispatch(8'hF1, 8'h33, "R7");

    // R3 write and lookup of the same entry in one cycle
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_bank_i = 2'd1; wr_ext_i = 1'b0; wr_opc_i = 8'h20;
    wr_uaddr_i = 12'hABC; wr_esc_i = 1'b0;
    disp_valid_i = 1'b1; disp_opc_i = 8'h20;
    @(negedge clk_i);
    wr_en_i = 1'b0; disp_valid_i = 1'b0;
    check("R3", "collision returns old word", uaddr_o, exp_ua(1, 0, 8'h20));
    m_ua[1][0][8'h20] = 12'hABC; m_esc[1][0][8'h20] = 0;
    dispatch(8'h20, 0, "R3");

    // random lookups, bank switches and rewrites
    for (int i = 0; i < 300; i++) begin
      int o, o2;
      if ($urandom_range(0, 3) == 0) set_bank($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) o = 8'hF0 + mbank;
      else o = $urandom_range(0, 255);
      o2 = $urandom_range(0, 255);
      if ($urandom_range(0, 9) == 0) begin
        int wb, we, wo;
        wb = $urandom_range(0, 3); we = $urandom_range(0, 1); wo = $urandom_range(0, 255);
        wr_one(wb, we, wo, 12'($urandom_range(0, 4095)), m_esc[wb][we][wo], 1'b0);
      end
      dispatch(o, o2, "R1");
    end

    // R11/R8/R9 parity faults
    set_bank(0);
    check("R9", "no error yet", par_err_o, 0);
    wr_one(0, 0, 8'h55, 12'h123, 1'b0, 1'b1);
    dispatch(8'h55, 0, "R8");
    dispatch(8'h56, 0, "R9");
    b0 = 0;
    wr_one(b0, 0, 8'hF0, m_ua[0][0][8'hF0], 1'b1, 1'b1);
    dispatch(8'hF0, 8'h10, "R8");
    wr_one(3, 1, 8'h66, 12'h321, 1'b0, 1'b1);
    set_bank(3);
    dispatch(8'hF3, 8'h66, "R11");
    check("R9", "sticky at end", par_err_o, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule